// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor and decides which interrupt that processor is offered. It keeps the processor's current priority, one pending slot (source number plus the priority that came with it) and an inter-processor interrupt (IPI) priority register. Interrupt sources send it presentation requests, each carrying a source number and a priority. Each request either takes the pending slot or is bounced back to its source. A request that wins the slot displaces any earlier external occupant, and that occupant is bounced back explicitly. The IPI competes for the same slot under the fixed source number 2. A single interrupt line to the processor is high while the slot is occupied.

The processor drives the block through a one-cycle command port. The commands are accept, end-of-interrupt, set current priority, set IPI priority and poll. Accept and poll return the 32-bit interrupt word, which holds the current priority in bits 31:24 and the pending source number in bits 23:0. They also return the IPI register. Towards the source layer the block emits three kinds of one-cycle pulses: bounces (for an incoming request or for an evicted occupant), end-of-interrupt notices, and resend requests. All outputs are registered: a command or request sampled at one rising edge shows its effect on the outputs right after that edge.

Top module: `prs_unit`

## Requirements
- R1: After reset the interrupt word is 0 (current priority 0, no source pending), the pending priority and the IPI priority are 0xFF, and the interrupt line and every pulse output are low.
- R2: Priorities are 8 bits, and a smaller value is more urgent. A pending source number of 0 means the slot is empty, and the pending priority is then 0xFF. While a source is pending, its priority is below 0xFF.
- R3: An incoming request is bounced (`bounce_valid`, `bounce_src` = its number) if its priority is not below the current priority, or if the slot holds a priority equal to or more urgent than its own. A bounced request leaves the state unchanged.
- R4: A request that is not bounced stores its number and priority in the slot and raises the interrupt line. If the slot held an external source, that source is evicted (`evict_valid`, `evict_src`) in the same cycle. The interrupt line is high exactly while the slot is occupied.
- R5: Command code 0 (take) returns the interrupt word and the IPI register on `rsp_*` and lowers the line. It then sets the current priority to the pending priority, empties the slot and sets the pending priority to 0xFF.
- R6: Command code 1 (done) sets the current priority to data bits 31:24 and pulses `eoi_valid` with `eoi_src` = data bits 23:0. If the slot is empty, it runs the resend step: an IPI load when the IPI priority is below the new current priority, and a `resend_req` pulse.
- R7: Command code 2 (set priority) takes its new value from data bits 7:0. If the value is lower than the current priority and the slot holds a priority not more urgent than it, the slot is emptied, the line drops and an external occupant is evicted. If the value is equal or higher and the slot is empty, the resend step of R6 runs.
- R8: Command code 3 (set IPI) stores data bits 7:0 as the IPI priority. If that value is below the current priority and the slot does not already hold an equal or more urgent priority, the slot is loaded with source 2 at the IPI priority and the line is raised. Any external occupant is evicted.
- R9: Command code 4 (poll) returns the interrupt word and the IPI register and changes no state.
- R10: A pending IPI that is displaced or cancelled produces no eviction pulse.
- R11: A request arriving in the same cycle as a command is bounced, and the command runs as if no request were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle presentation request from a source |
| req_src | input | 24 | Source number of the request |
| req_prio | input | 8 | Priority of the request |
| cmd_valid | input | 1 | One-cycle processor command |
| cmd_op | input | 3 | Command code: 0 take, 1 done, 2 set priority, 3 set IPI, 4 poll; 5 to 7 do nothing |
| cmd_data | input | 32 | Command operand |
| irq_o | output | 1 | Interrupt line to the processor |
| bounce_valid | output | 1 | Pulse: incoming request refused |
| bounce_src | output | 24 | Number of the refused request |
| evict_valid | output | 1 | Pulse: pending external source displaced or cancelled |
| evict_src | output | 24 | Number of the evicted source |
| eoi_valid | output | 1 | Pulse: end-of-interrupt forwarded to sources |
| eoi_src | output | 24 | Source number carried by the end-of-interrupt |
| resend_req | output | 1 | Pulse: sources asked to present held interrupts again |
| rsp_valid | output | 1 | Pulse: response to take or poll |
| rsp_word | output | 32 | Interrupt word returned (priority 31:24, source 23:0) |
| rsp_ipi | output | 8 | IPI priority register returned |

## Verification
The in-line properties assume that no source ever presents number 0, because that value means an empty slot. They also assume that no external source uses number 2, so that an eviction can always be traced back to an external occupant. The bench draws request numbers from 3 upward, so both assumptions hold. Commands and requests are pulses of one cycle each, and the bench keeps the command code within 0 to 4. Some of the random cycles deliberately put a request and a command in the same cycle, so that the same-cycle bounce is exercised.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    OP_TAKE = 3'd0,
    OP_DONE = 3'd1,
    OP_PRIO = 3'd2,
    OP_IPI  = 3'd3,
    OP_PEEK = 3'd4
  } prs_op_e;
endpackage

// File: rtl/prs_req_judge.sv
module prs_req_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              slot_busy,
  input  logic [PRIO_W-1:0] slot_prio,
  output logic              take
);
  logic beats_current;
  logic beats_slot;

  always_comb begin
    beats_current = req_prio < cur_prio;
    beats_slot    = !slot_busy || (req_prio < slot_prio);
    take          = beats_current && beats_slot;
  end
endmodule

// File: rtl/prs_ipi_gate.sv
module prs_ipi_gate #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] ref_prio,
  input  logic              slot_busy,
  input  logic [PRIO_W-1:0] slot_prio,
  output logic              fire
);
  logic below_ref;
  logic slot_wins;

  always_comb begin
    below_ref = ipi_prio < ref_prio;
    slot_wins = slot_busy && (slot_prio <= ipi_prio);
    fire      = below_ref && !slot_wins;
  end
endmodule

// File: rtl/prs_unit.sv
module prs_unit #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [SRC_W-1:0]         req_src,
  input  logic [PRIO_W-1:0]        req_prio,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
  output logic                     irq_o,
  output logic                     bounce_valid,
  output logic [SRC_W-1:0]         bounce_src,
  output logic                     evict_valid,
  output logic [SRC_W-1:0]         evict_src,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src,
  output logic                     resend_req,
  output logic                     rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]  rsp_word,
  output logic [PRIO_W-1:0]        rsp_ipi
);
  import prs_pkg::*;

  localparam int REG_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  SRC_NONE  = '0;
  localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

  // architectural state
  logic [PRIO_W-1:0] cur_q;
  logic [SRC_W-1:0]  slot_src_q;
  logic [PRIO_W-1:0] slot_prio_q;
  logic [PRIO_W-1:0] ipi_q;
  logic              slot_ext_q;
  logic              irq_q;

  // decoded command fields
  prs_op_e           op;
  logic [PRIO_W-1:0] data_lo;
  logic [PRIO_W-1:0] data_hi;
  logic [SRC_W-1:0]  data_src;
  logic              slot_busy;
  logic [PRIO_W-1:0] ipi_cand;
  logic [PRIO_W-1:0] ipi_ref;
  logic              req_take;
  logic              ipi_fire;

  always_comb begin
    op        = prs_op_e'(cmd_op);
    data_lo   = cmd_data[PRIO_W-1:0];
    data_hi   = cmd_data[REG_W-1 -: PRIO_W];
    data_src  = cmd_data[SRC_W-1:0];
    slot_busy = slot_src_q != SRC_NONE;
    ipi_cand  = (op == OP_IPI) ? data_lo : ipi_q;
    case (op)
      OP_IPI:  ipi_ref = cur_q;
      OP_DONE: ipi_ref = data_hi;
      default: ipi_ref = data_lo;
    endcase
  end

  prs_req_judge #(.PRIO_W(PRIO_W)) u_judge (
    .req_prio  (req_prio),
    .cur_prio  (cur_q),
    .slot_busy (slot_busy),
    .slot_prio (slot_prio_q),
    .take      (req_take)
  );

  prs_ipi_gate #(.PRIO_W(PRIO_W)) u_ipi (
    .ipi_prio  (ipi_cand),
    .ref_prio  (ipi_ref),
    .slot_busy (slot_busy),
    .slot_prio (slot_prio_q),
    .fire      (ipi_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q        <= '0;
      slot_src_q   <= SRC_NONE;
      slot_prio_q  <= PRIO_IDLE;
      ipi_q        <= PRIO_IDLE;
      slot_ext_q   <= 1'b0;
      irq_q        <= 1'b0;
      bounce_valid <= 1'b0;
      bounce_src   <= '0;
      evict_valid  <= 1'b0;
      evict_src    <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_req   <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_word     <= '0;
      rsp_ipi      <= '0;
    end else begin
      bounce_valid <= 1'b0;
      evict_valid  <= 1'b0;
      eoi_valid    <= 1'b0;
      resend_req   <= 1'b0;
      rsp_valid    <= 1'b0;
      if (cmd_valid) begin
        if (req_valid) begin
          bounce_valid <= 1'b1;
          bounce_src   <= req_src;
        end
        case (op)
          OP_TAKE: begin
            rsp_valid   <= 1'b1;
            rsp_word    <= {cur_q, slot_src_q};
            rsp_ipi     <= ipi_q;
            irq_q       <= 1'b0;
            cur_q       <= slot_prio_q;
            slot_src_q  <= SRC_NONE;
            slot_prio_q <= PRIO_IDLE;
            slot_ext_q  <= 1'b0;
          end
          OP_PEEK: begin
            rsp_valid <= 1'b1;
            rsp_word  <= {cur_q, slot_src_q};
            rsp_ipi   <= ipi_q;
          end
          OP_DONE: begin
            cur_q     <= data_hi;
            eoi_valid <= 1'b1;
            eoi_src   <= data_src;
            if (!slot_busy) begin
              resend_req <= 1'b1;
              if (ipi_fire) begin
                slot_src_q  <= SRC_IPI;
                slot_prio_q <= ipi_q;
                slot_ext_q  <= 1'b0;
                irq_q       <= 1'b1;
              end
            end
          end
          OP_PRIO: begin
            cur_q <= data_lo;
            if (data_lo < cur_q) begin
              if (slot_busy && (data_lo <= slot_prio_q)) begin
                slot_src_q  <= SRC_NONE;
                slot_prio_q <= PRIO_IDLE;
                slot_ext_q  <= 1'b0;
                irq_q       <= 1'b0;
                if (slot_ext_q) begin
                  evict_valid <= 1'b1;
                  evict_src   <= slot_src_q;
                end
              end
            end else if (!slot_busy) begin
              resend_req <= 1'b1;
              if (ipi_fire) begin
                slot_src_q  <= SRC_IPI;
                slot_prio_q <= ipi_q;
                slot_ext_q  <= 1'b0;
                irq_q       <= 1'b1;
              end
            end
          end
          OP_IPI: begin
            ipi_q <= data_lo;
            if (ipi_fire) begin
              if (slot_busy && slot_ext_q) begin
                evict_valid <= 1'b1;
                evict_src   <= slot_src_q;
              end
              slot_src_q  <= SRC_IPI;
              slot_prio_q <= data_lo;
              slot_ext_q  <= 1'b0;
              irq_q       <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (req_valid) begin
        if (req_take) begin
          if (slot_busy && slot_ext_q) begin
            evict_valid <= 1'b1;
            evict_src   <= slot_src_q;
          end
          slot_src_q  <= req_src;
          slot_prio_q <= req_prio;
          slot_ext_q  <= 1'b1;
          irq_q       <= 1'b1;
        end else begin
          bounce_valid <= 1'b1;
          bounce_src   <= req_src;
        end
      end
    end
  end

  assign irq_o = irq_q;

  // R2: empty slot and idle pending priority go together
  a_r2_idle_prio: assert property (@(posedge clk) disable iff (rst)
    (slot_src_q == SRC_NONE) == (slot_prio_q == PRIO_IDLE));

  // R4: line level follows slot occupancy
  a_r4_line_tracks_slot: assert property (@(posedge clk) disable iff (rst)
    irq_q == (slot_src_q != SRC_NONE));

  // R3: a refused request without a command leaves the slot alone
  a_r3_bounce_keeps_slot: assert property (@(posedge clk) disable iff (rst)
    (bounce_valid && !$past(cmd_valid)) |-> ($stable(slot_src_q) && $stable(slot_prio_q)));

  // R5: after take the slot is empty and the line is low
  a_r5_take_clears: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid && !rst && cmd_op == OP_TAKE) |-> (slot_src_q == SRC_NONE && !irq_q));

  // R9: poll leaves all state untouched
  a_r9_peek_stable: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid && !rst && cmd_op == OP_PEEK) |->
      ($stable(cur_q) && $stable(slot_src_q) && $stable(slot_prio_q) && $stable(ipi_q)));

  // R10: evictions only ever name an external occupant
  a_r10_evict_external: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(slot_ext_q));
endmodule

// File: tb/sim_prs_unit.sv
`timescale 1ns/1ps
module sim_prs_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [23:0] req_src;
  logic [7:0]  req_prio;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        irq_o, bounce_valid, evict_valid, eoi_valid, resend_req, rsp_valid;
  logic [23:0] bounce_src, evict_src, eoi_src;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_ipi;

  always #2.5 clk = ~clk;

  prs_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .irq_o(irq_o),
    .bounce_valid(bounce_valid), .bounce_src(bounce_src), .evict_valid(evict_valid),
    .evict_src(evict_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi)
  );

  int n_run = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int m_cur, m_src, m_pp, m_ipi;
  bit m_ext, m_irq;
  bit e_bv, e_ev, e_eo, e_rs, e_rv;
  int e_bsrc, e_esrc, e_osrc;
  logic [31:0] e_word;
  logic [7:0]  e_ipi;

  task automatic ipi_check(input int p);
    if (m_src != 0 && m_pp <= p) return;
    if (m_src != 0 && m_ext) begin e_ev = 1; e_esrc = m_src; end
    m_src = 2; m_pp = p; m_ext = 0; m_irq = 1;
  endtask

  task automatic resend_step();
    if (m_ipi < m_cur) ipi_check(m_ipi);
    e_rs = 1;
  endtask

  task automatic model_step();
    int v;
    e_bv = 0; e_ev = 0; e_eo = 0; e_rs = 0; e_rv = 0;
    if (rst) begin
      m_cur = 0; m_src = 0; m_pp = 255; m_ipi = 255; m_ext = 0; m_irq = 0;
      e_word = 0; e_ipi = 0;
      return;
    end
    if (cmd_valid) begin
      if (req_valid) begin e_bv = 1; e_bsrc = req_src; end
      case (cmd_op)
        3'd0: begin
          e_rv = 1; e_word = {m_cur[7:0], m_src[23:0]}; e_ipi = m_ipi[7:0];
          m_irq = 0; m_cur = m_pp; m_src = 0; m_pp = 255; m_ext = 0;
        end
        3'd4: begin
          e_rv = 1; e_word = {m_cur[7:0], m_src[23:0]}; e_ipi = m_ipi[7:0];
        end
        3'd1: begin
          m_cur = cmd_data[31:24];
          e_eo = 1; e_osrc = cmd_data[23:0];
          if (m_src == 0) resend_step();
        end
        3'd2: begin
          v = cmd_data[7:0];
          if (v < m_cur) begin
            m_cur = v;
            if (m_src != 0 && v <= m_pp) begin
              if (m_ext) begin e_ev = 1; e_esrc = m_src; end
              m_src = 0; m_pp = 255; m_ext = 0; m_irq = 0;
            end
          end else begin
            m_cur = v;
            if (m_src == 0) resend_step();
          end
        end
        3'd3: begin
          m_ipi = cmd_data[7:0];
          if (m_ipi < m_cur) ipi_check(m_ipi);
        end
        default: ;
      endcase
    end else if (req_valid) begin
      if (req_prio >= m_cur || (m_src != 0 && m_pp <= req_prio)) begin
        e_bv = 1; e_bsrc = req_src;
      end else begin
        if (m_src != 0 && m_ext) begin e_ev = 1; e_esrc = m_src; end
        m_src = req_src; m_pp = req_prio; m_ext = 1; m_irq = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    n_run++;
    if (irq_o !== m_irq) begin bad = 1; $display("FAIL %s irq_o got %0b exp %0b", tag, irq_o, m_irq); end
    if (bounce_valid !== e_bv) begin bad = 1; $display("FAIL %s bounce_valid got %0b exp %0b", tag, bounce_valid, e_bv); end
    else if (e_bv && bounce_src !== 24'(e_bsrc)) begin bad = 1; $display("FAIL %s bounce_src got %h exp %h", tag, bounce_src, e_bsrc); end
    if (evict_valid !== e_ev) begin bad = 1; $display("FAIL %s evict_valid got %0b exp %0b", tag, evict_valid, e_ev); end
    else if (e_ev && evict_src !== 24'(e_esrc)) begin bad = 1; $display("FAIL %s evict_src got %h exp %h", tag, evict_src, e_esrc); end
    if (eoi_valid !== e_eo) begin bad = 1; $display("FAIL %s eoi_valid got %0b exp %0b", tag, eoi_valid, e_eo); end
    else if (e_eo && eoi_src !== 24'(e_osrc)) begin bad = 1; $display("FAIL %s eoi_src got %h exp %h", tag, eoi_src, e_osrc); end
    if (resend_req !== e_rs) begin bad = 1; $display("FAIL %s resend_req got %0b exp %0b", tag, resend_req, e_rs); end
    if (rsp_valid !== e_rv) begin bad = 1; $display("FAIL %s rsp_valid got %0b exp %0b", tag, rsp_valid, e_rv); end
    else if (e_rv && (rsp_word !== e_word || rsp_ipi !== e_ipi)) begin
      bad = 1; $display("FAIL %s rsp got %h/%h exp %h/%h", tag, rsp_word, rsp_ipi, e_word, e_ipi);
    end
    if (bad) n_bad++;
  endtask

  // inputs are already set at a falling edge; model, clock, then compare
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1 compare(tag);
    @(negedge clk);
    req_valid = 0; cmd_valid = 0;
  endtask

  task automatic req(input int s, input int p, input string tag);
    req_valid = 1; req_src = 24'(s); req_prio = 8'(p); tick(tag);
  endtask

  task automatic cmd(input int op, input logic [31:0] d, input string tag);
    cmd_valid = 1; cmd_op = 3'(op); cmd_data = d; tick(tag);
  endtask

  task automatic expect_word(input logic [31:0] w, input string tag);
    n_run++;
    if (rsp_word !== w) begin
      n_bad++; $display("FAIL %s rsp_word got %h exp %h", tag, rsp_word, w);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_src = 0; req_prio = 0;
    cmd_valid = 0; cmd_op = 0; cmd_data = 0;
    @(negedge clk);
    tick("R1 reset");
    tick("R1 reset");
    rst = 0;
    tick("R1 idle after reset");
    req(24'h100, 1, "R3 prio zero rejects all");
    cmd(2, 32'hFF, "R7 raise with empty slot resends");
    req(24'h100, 5, "R4 take empty slot");
    req(24'h200, 5, "R3 equal pending bounces");
    req(24'h300, 3, "R4 preempt evicts earlier");
    cmd(4, 0, "R9 poll");
    expect_word(32'hFF000300, "R9 poll word");
    cmd(0, 0, "R5 take");
    expect_word(32'hFF000300, "R5 take word");
    req(24'h400, 3, "R3 not below current bounces");
    cmd(3, 32'h1, "R8 IPI loads slot");
    req(24'h500, 0, "R10 IPI displaced silently");
    cmd(1, 32'hFF000300, "R6 done with slot busy");
    cmd(2, 32'h0, "R7 lower cancels and evicts");
    cmd(2, 32'hFF, "R7 raise reloads IPI");
    cmd(2, 32'h0, "R10 IPI cancel silent");
    cmd(2, 32'hFF, "R8 IPI back");
    cmd(0, 0, "R5 take IPI");
    expect_word(32'hFF000002, "R8 IPI number");
    cmd_valid = 1; cmd_op = 3'd4; cmd_data = 0;
    req_valid = 1; req_src = 24'h600; req_prio = 0;
    tick("R11 command beats request");
    cmd(1, 32'hFF000002, "R6 done resend and IPI");
    cmd(3, 32'hFF, "R8 IPI masked");
    cmd(0, 0, "R2 take leaves idle");
    cmd(1, 32'hFF000002, "R6 done resend no IPI");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) < 4) begin
        cmd_valid = 1;
        cmd_op = 3'($urandom_range(0, 4));
        cmd_data = {8'($urandom_range(0, 255)), 24'($urandom_range(3, 4095))};
        if ($urandom_range(0, 3) == 0) cmd_data[7:0] = 8'hFF;
      end
      if ($urandom_range(0, 1) == 1) begin
        req_valid = 1;
        req_src   = 24'($urandom_range(3, 4095));
        req_prio  = 8'($urandom_range(0, 255));
      end
      tick("R2 R3 R4 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule